// File: doc/BRIEF.md
# 8-bit ALU with per-operation flag rules

This block is the arithmetic and logic datapath of a small 8-bit processor core. Each cycle it receives an accumulator value, a second operand, the current flag byte and a 4-bit operation code. In the same cycle, through combinational logic only, it produces the 8-bit result, a write strobe for the accumulator and the next flag byte. When the operation is marked valid, the next flag byte is also captured in an internal flag register, which is visible on its own output.

Every operation has its own rule for each flag. A flag may be computed from the operation, copied from the incoming byte, forced to 0 or forced to 1. The parity/overflow bit is signed overflow for arithmetic and even parity for logic operations. Instruction decoding, decimal adjust, 16-bit arithmetic, shifts and rotates are handled elsewhere.

The block contains no sequencing state beyond the flag register. Its only two conditions are reset (flag register cleared) and running (the flag register loads on every valid operation).

Top module: `alu8_flags`

## Requirements
- R1: The flag byte places S (sign) at bit 7, Z (zero) at bit 6, H (half carry) at bit 4, P/V at bit 2, N (subtract) at bit 1 and C (carry) at bit 0. Bits 5 and 3 of `flags_next` are always 0, even when they are 1 on `flags_in`.
- R2: Op 0 (add) and op 1 (add plus C) give result = acc + opnd (+C) mod 256. S is result bit 7, Z is set when the result is 0, H is the carry out of bit 3, P/V is signed overflow, C is the carry out of bit 7, and N = 0. `acc_we` = 1.
- R3: Op 2 (subtract), op 3 (subtract minus C) and op 5 (negate, computed as 0 - acc) give the difference mod 256. S and Z follow the result, H is the borrow out of bit 3, P/V is signed overflow, C is the borrow out of bit 7, and N = 1. `acc_we` = 1.
- R4: Op 4 (compare) sets all flags exactly as op 2 does, and `result` shows acc - opnd. `acc_we` = 0.
- R5: Op 6 (AND), op 7 (OR) and op 8 (XOR) give the bitwise result with S and Z from the result. P/V is 1 when the result has an even number of 1 bits. H is 1 for AND and 0 for OR and XOR. N = 0 and C = 0. `acc_we` = 1.
- R6: Op 9 (increment) and op 10 (decrement) give acc ± 1 with S, Z, H and P/V (overflow) as in R2 and R3. N is 0 for increment and 1 for decrement. C is copied from `flags_in`. `acc_we` = 1.
- R7: Op 11 (complement) gives result = ~acc and sets H = 1 and N = 1. S, Z, P/V and C are copied from `flags_in`. `acc_we` = 1.
- R8: Op 12 (set carry) makes C = 1, H = 0 and N = 0. Op 13 (invert carry) makes C = the inverse of the incoming C, H = the incoming C and N = 0. Both copy S, Z and P/V from `flags_in`, and both have `acc_we` = 0.
- R9: Reset clears `flags_q` to 0. On a clock edge with `op_valid` = 1, `flags_q` takes the value `flags_next` had before the edge. With `op_valid` = 0, `flags_q` holds its value.
- R10: Op codes 14 and 15 have no effect: `result` = acc, `acc_we` = 0, and `flags_next` equals `flags_in` with bits 5 and 3 cleared.
- R11: `acc_we` is 0 whenever `op_valid` is 0, whatever the op code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation is real this cycle |
| op_sel | input | 4 | Operation code (see requirements) |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Second operand |
| flags_in | input | 8 | Incoming flag byte |
| result | output | 8 | Operation result |
| acc_we | output | 1 | Accumulator write strobe |
| flags_next | output | 8 | Updated flag byte (combinational) |
| flags_q | output | 8 | Registered flag byte |

## Verification
Every op code, including the two unused codes, is applied with all 256 accumulator values against sixteen second operands. The operand set includes 0x00, 0x0F, 0x10, 0x7F, 0x80 and 0xFF, which separate a nibble carry from a full carry and signed overflow from unsigned wrap. The incoming flag byte is random, so carry-in and the copied flags take both values. This also shows whether a flag that should be copied really is copied, rather than recomputed or forced. Every seventh step drops `op_valid`, which shows whether the flag register holds and the write strobe stays low.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int DATA_W = 8;
    localparam int OP_W   = 4;
    localparam int HALF_B = DATA_W / 2;

    localparam int FL_S  = 7;
    localparam int FL_Z  = 6;
    localparam int FL_H  = 4;
    localparam int FL_PV = 2;
    localparam int FL_N  = 1;
    localparam int FL_C  = 0;
    localparam logic [7:0] FL_PAD_MASK = 8'hD7;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_CMP = 4'd4,
        OP_NEG = 4'd5,
        OP_AND = 4'd6,
        OP_OR  = 4'd7,
        OP_XOR = 4'd8,
        OP_INC = 4'd9,
        OP_DEC = 4'd10,
        OP_CPL = 4'd11,
        OP_SCF = 4'd12,
        OP_CCF = 4'd13
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } logic_fn_e;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cy_out,
    output logic         half_out,
    output logic         ovf
);
    localparam int HB = W / 2;

    logic [W-1:0] b_eff;
    logic         c0;
    logic [HB:0]  lo;
    logic [W:0]   full;

    always_comb begin
        b_eff    = sub ? ~b : b;
        c0       = sub ? ~cin : cin;
        lo       = {1'b0, a[HB-1:0]} + {1'b0, b_eff[HB-1:0]} + {{HB{1'b0}}, c0};
        full     = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c0};
        sum      = full[W-1:0];
        cy_out   = full[W] ^ sub;
        half_out = lo[HB] ^ sub;
        ovf      = (a[W-1] == b_eff[W-1]) && (full[W-1] != a[W-1]);
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic_fn_e    fn,
    output logic [W-1:0] res,
    output logic         par_even
);
    always_comb begin
        unique case (fn)
            LG_AND:  res = a & b;
            LG_OR:   res = a | b;
            LG_XOR:  res = a ^ b;
            default: res = a ^ b;
        endcase
        par_even = ~(^res);
    end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
    import alu8_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_valid,
    input  logic [3:0] op_sel,
    input  logic [7:0] acc_in,
    input  logic [7:0] opnd_in,
    input  logic [7:0] flags_in,
    output logic [7:0] result,
    output logic       acc_we,
    output logic [7:0] flags_next,
    output logic [7:0] flags_q
);
    alu_op_e           op;
    logic [DATA_W-1:0] as_a, as_b, as_sum, lg_res;
    logic              as_cin, as_sub, as_cy, as_half, as_ovf, lg_par;
    logic_fn_e         lg_fn;
    logic              we_raw;
    logic              cin_f;

    assign op    = alu_op_e'(op_sel);
    assign cin_f = flags_in[FL_C];

    // adder operand steering
    always_comb begin
        as_a   = acc_in;
        as_b   = opnd_in;
        as_cin = 1'b0;
        as_sub = 1'b0;
        case (op)
            OP_ADC: as_cin = cin_f;
            OP_SUB, OP_CMP: as_sub = 1'b1;
            OP_SBC: begin as_sub = 1'b1; as_cin = cin_f; end
            OP_NEG: begin as_a = '0; as_b = acc_in; as_sub = 1'b1; end
            OP_INC: as_b = 8'd1;
            OP_DEC: begin as_b = 8'd1; as_sub = 1'b1; end
            default: ;
        endcase
    end

    always_comb begin
        case (op)
            OP_AND:  lg_fn = LG_AND;
            OP_OR:   lg_fn = LG_OR;
            default: lg_fn = LG_XOR;
        endcase
    end

    alu8_addsub #(.W(DATA_W)) u_addsub (
        .a(as_a), .b(as_b), .cin(as_cin), .sub(as_sub),
        .sum(as_sum), .cy_out(as_cy), .half_out(as_half), .ovf(as_ovf)
    );

    alu8_logic #(.W(DATA_W)) u_logic (
        .a(acc_in), .b(opnd_in), .fn(lg_fn), .res(lg_res), .par_even(lg_par)
    );

    // result, write strobe and flag rules
    always_comb begin
        logic [7:0] fl;
        fl     = flags_in & FL_PAD_MASK;
        result = acc_in;
        we_raw = 1'b0;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_NEG: begin
                result    = as_sum;
                we_raw    = (op != OP_CMP);
                fl[FL_S]  = as_sum[DATA_W-1];
                fl[FL_Z]  = (as_sum == '0);
                fl[FL_H]  = as_half;
                fl[FL_PV] = as_ovf;
                fl[FL_N]  = as_sub;
                fl[FL_C]  = as_cy;
            end
            OP_AND, OP_OR, OP_XOR: begin
                result    = lg_res;
                we_raw    = 1'b1;
                fl[FL_S]  = lg_res[DATA_W-1];
                fl[FL_Z]  = (lg_res == '0);
                fl[FL_H]  = (op == OP_AND);
                fl[FL_PV] = lg_par;
                fl[FL_N]  = 1'b0;
                fl[FL_C]  = 1'b0;
            end
            OP_INC, OP_DEC: begin
                result    = as_sum;
                we_raw    = 1'b1;
                fl[FL_S]  = as_sum[DATA_W-1];
                fl[FL_Z]  = (as_sum == '0);
                fl[FL_H]  = as_half;
                fl[FL_PV] = as_ovf;
                fl[FL_N]  = as_sub;
            end
            OP_CPL: begin
                result   = ~acc_in;
                we_raw   = 1'b1;
                fl[FL_H] = 1'b1;
                fl[FL_N] = 1'b1;
            end
            OP_SCF: begin
                fl[FL_C] = 1'b1;
                fl[FL_H] = 1'b0;
                fl[FL_N] = 1'b0;
            end
            OP_CCF: begin
                fl[FL_H] = cin_f;
                fl[FL_C] = ~cin_f;
                fl[FL_N] = 1'b0;
            end
            default: ;
        endcase
        flags_next = fl;
    end

    assign acc_we = op_valid & we_raw;

    // flag register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flags_q <= '0;
        else if (op_valid) flags_q <= flags_next;
    end

    // assertions
    assert_pad_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        flags_q[5] == 1'b0 && flags_q[3] == 1'b0);

    assert_add_nflag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_sel == 4'd0 || op_sel == 4'd1)) |-> (!flags_next[FL_N] && acc_we));

    assert_sub_nflag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_sel == 4'd2 || op_sel == 4'd3 || op_sel == 4'd5)) |-> flags_next[FL_N]);

    assert_cmp_nowrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'd4) |-> !acc_we);

    assert_logic_nc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel >= 4'd6 && op_sel <= 4'd8) |->
            (!flags_next[FL_N] && !flags_next[FL_C] && flags_next[FL_Z] == (result == 8'd0)));

    assert_incdec_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'd9 || op_sel == 4'd10) |-> (flags_next[FL_C] == flags_in[FL_C]));

    assert_cpl_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'd11) |-> (result == ~acc_in));

    assert_scf_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'd12) |-> (flags_next[FL_C] && !flags_next[FL_N] && !acc_we));

    assert_flag_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (flags_q == $past(flags_next)));

    assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(flags_q));

    assert_unused_nowrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel >= 4'd14) |-> (!acc_we && result == acc_in));

    assert_invalid_nowrite_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> !acc_we);
endmodule

// File: tb/alu8_flags_bench.sv
module alu8_flags_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_sel = '0;
    logic [7:0] acc_in = '0, opnd_in = '0, flags_in = '0;
    logic [7:0] result, flags_next, flags_q;
    logic       acc_we;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] exp_q = '0;

    always #5 clk = ~clk;

    alu8_flags u_alu8_flags (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .acc_in(acc_in), .opnd_in(opnd_in), .flags_in(flags_in),
        .result(result), .acc_we(acc_we), .flags_next(flags_next), .flags_q(flags_q)
    );

    function automatic string tag_of(int op);
        case (op)
            0, 1:       return "R2";
            2, 3, 5:    return "R3";
            4:          return "R4";
            6, 7, 8:    return "R5";
            9, 10:      return "R6";
            11:         return "R7";
            12, 13:     return "R8";
            default:    return "R10";
        endcase
    endfunction

    // behavioural reference: returns {write, result, flags}
    function automatic logic [16:0] ref_alu(int op, int a, int b, logic [7:0] f);
        int ci, r, sa, sb, sv, lo, ones;
        logic s, z, h, pv, n, c, we;
        logic [7:0] res;
        ci = f[0];
        sa = (a >= 128) ? a - 256 : a;
        sb = (b >= 128) ? b - 256 : b;
        s = f[7]; z = f[6]; h = f[4]; pv = f[2]; n = f[1]; c = f[0];
        we = 1'b0; res = a[7:0];
        case (op)
            0, 1, 9: begin
                if (op == 9) begin b = 1; sb = 1; ci = 0; end
                if (op == 0) ci = 0;
                r = a + b + ci; lo = (a % 16) + (b % 16) + ci; sv = sa + sb + ci;
                res = r[7:0]; we = 1'b1; h = (lo > 15); pv = (sv > 127 || sv < -128);
                n = 1'b0;
                if (op != 9) c = (r > 255);
                s = res[7]; z = (res == 0);
            end
            2, 3, 4, 5, 10: begin
                if (op == 5) begin b = a; sb = sa; a = 0; sa = 0; ci = 0; end
                if (op == 10) begin b = 1; sb = 1; ci = 0; end
                if (op == 2 || op == 4) ci = 0;
                r = a - b - ci; lo = (a % 16) - (b % 16) - ci; sv = sa - sb - ci;
                res = r[7:0]; we = (op != 4); h = (lo < 0); pv = (sv > 127 || sv < -128);
                n = 1'b1;
                if (op != 10) c = (r < 0);
                s = res[7]; z = (res == 0);
            end
            6, 7, 8: begin
                if (op == 6) res = a[7:0] & b[7:0];
                else if (op == 7) res = a[7:0] | b[7:0];
                else res = a[7:0] ^ b[7:0];
                ones = 0;
                for (int i = 0; i < 8; i++) ones += res[i];
                we = 1'b1; s = res[7]; z = (res == 0); h = (op == 6);
                pv = (ones % 2 == 0); n = 1'b0; c = 1'b0;
            end
            11: begin res = ~a[7:0]; we = 1'b1; h = 1'b1; n = 1'b1; end
            12: begin c = 1'b1; h = 1'b0; n = 1'b0; end
            13: begin h = f[0]; c = ~f[0]; n = 1'b0; end
            default: ;
        endcase
        return {we, res, s, z, 1'b0, h, 1'b0, pv, n, c};
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%02h expected=%02h (op=%0d a=%02h b=%02h f=%02h)",
                     req, what, act, exp, op_sel, acc_in, opnd_in, flags_in);
        end
    endtask

    logic [7:0] bset [16] = '{8'h00, 8'h01, 8'h0F, 8'h10, 8'h7F, 8'h80, 8'h81, 8'hFF,
                              8'h08, 8'h37, 8'h55, 8'hAA, 8'hC3, 8'hF0, 8'h6E, 8'h99};

    initial begin
        logic [16:0] e;
        int step;
        step = 0;
        repeat (3) @(negedge clk);
        chk("R9", flags_q, 8'h00, "flags_q in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", flags_q, 8'h00, "flags_q after reset");
        for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < 256; a++) begin
                for (int k = 0; k < 16; k++) begin
                    @(negedge clk);
                    chk("R9", flags_q, exp_q, "flags_q");
                    op_sel   = op[3:0];
                    acc_in   = a[7:0];
                    opnd_in  = bset[k];
                    flags_in = $urandom;
                    op_valid = (step % 7 != 6);
                    step++;
                    #2;
                    e = ref_alu(op, a, int'(bset[k]), flags_in);
                    chk(tag_of(op), result, e[15:8], "result");
                    chk(tag_of(op), flags_next, e[7:0], "flags_next");
                    chk("R1", {2'b00, flags_next[5], 2'b00, flags_next[3], 2'b00}, 8'h00, "pad bits");
                    if (op_valid)
                        chk(tag_of(op), {7'd0, acc_we}, {7'd0, e[16]}, "acc_we");
                    else
                        chk("R11", {7'd0, acc_we}, 8'h00, "acc_we while idle");
                    if (op_valid) exp_q = e[7:0];
                end
            end
        end
        @(negedge clk);
        chk("R9", flags_q, exp_q, "flags_q final");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1900000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule